// File: doc/BRIEF.md
# Host Programmed-I/O Data Port for Local Packet Memory

This block lets a host move data between its bus and the local packet memory of a network controller through one data port, with no address on the host side. The register block loads a remote address and a remote byte count. After that, every access to the data port reads or writes one beat at the current address. The address then steps forward by the beat width and the count steps down by the same amount. A beat is a byte or a little-endian 16-bit word, chosen by a configuration bit. A host can also ask for a 32-bit beat. When the count runs out, the block sends a one-cycle strobe to the register block, which sets its remote-DMA-complete status bit.

Local memory has two windows. A small station-address PROM sits at the bottom of the address space. A packet RAM starts at a configurable base. Byte addresses that fall outside both windows read as 0xFF, and writes to them have no effect. The address wraps from the ring's stop page back to its start page, so a transfer can run through the receive ring without the host reloading the address.

Top module: `rdma_data_port`

## Requirements
- R1: The beat width is 4 bytes when `acc_long` is 1. Otherwise it is 2 bytes when `word_mode` is 1 and 1 byte when `word_mode` is 0. Each performed access advances `cur_addr` by that width, measured from the unaligned current address.
- R2: If the advanced address equals `{ring_stop_pg, 8'h00}`, `cur_addr` is loaded with `{ring_start_pg, 8'h00}` instead.
- R3: If `cur_count` is less than or equal to the width, `cur_count` becomes 0 and `dma_done_set` is high for exactly one cycle. Otherwise `cur_count` drops by the width.
- R4: A write while `cur_count` is 0 has no effect: memory, `cur_addr` and `cur_count` stay the same and `dma_done_set` stays low.
- R5: A read while `cur_count` is 0 is still performed. It returns data, advances the address and pulses `dma_done_set`.
- R6: Byte address 0..31 is the PROM and byte address RAM_BASE..RAM_BASE+RAM_BYTES-1 is the packet RAM. Any byte lane outside both windows reads 0xFF and is not written. Lanes are checked one at a time.
- R7: For 2- and 4-byte beats the memory address has bit 0 cleared. The lowest address maps to `rd_data[7:0]` and `acc_wdata[7:0]`, and the higher addresses follow in ascending byte lanes. Lanes above the width read as 0.
- R8: Reset sets PROM byte 2i and byte 2i+1 to source byte i. Source bytes 0..5 are STATION_ADDR from its most significant byte down, bytes 14 and 15 are 0x57, and the rest are 0. The PROM can be written.
- R9: `rd_data` and `rd_valid` are registered. They are valid in the cycle after a read is accepted, and `rd_valid` is low after writes.
- R10: An `addr_load` or `cnt_load` in the same cycle as an access overrides that access's update of the loaded register.
- R11: After reset, `cur_addr`, `cur_count`, `rd_valid` and `dma_done_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_mode | input | 1 | 1: 16-bit beats, 0: byte beats |
| ring_start_pg | input | PAGE_W | Ring start page (address bits above the low byte) |
| ring_stop_pg | input | PAGE_W | Ring stop page, one past the last page |
| addr_load | input | 1 | Load `addr_value` into the remote address |
| addr_value | input | PAGE_W+8 | Remote address to load |
| cnt_load | input | 1 | Load `cnt_value` into the remote count |
| cnt_value | input | CNT_W | Remote byte count to load |
| acc_valid | input | 1 | Host data-port access this cycle |
| acc_write | input | 1 | 1: write, 0: read |
| acc_long | input | 1 | Request a 32-bit beat |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| cur_addr | output | PAGE_W+8 | Current remote address |
| cur_count | output | CNT_W | Remaining remote byte count |
| dma_done_set | output | 1 | One-cycle set strobe for the DMA-complete status |

## Verification
The checker watches the following on every cycle: that read data is valid one cycle after a read, that the count steps down by exactly the beat width, that a completion strobe only occurs with a zero count, that a zero-count write leaves the address unchanged, that the address never rests on the stop page after an access, and that a load overrides an access. Only the bench scenarios can show the memory contents. These include little-endian byte placement, the 0xFF fill for each lane outside the windows, clearing of the alignment bit, the PROM image after reset, and the fact that a blocked write really leaves memory untouched.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    XF_BYTE = 2'd0,
    XF_WORD = 2'd1,
    XF_LONG = 2'd2
  } xfer_e;

  function automatic logic [2:0] xfer_bytes(input xfer_e xf);
    case (xf)
      XF_LONG: xfer_bytes = 3'd4;
      XF_WORD: xfer_bytes = 3'd2;
      default: xfer_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rdma_addr_seq.sv
module rdma_addr_seq #(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int AW    = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_value,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              step_en,
  input  logic [2:0]        step_bytes,
  output logic [AW-1:0]     cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              done_set
);
  logic [AW-1:0]    addr_q, addr_d, addr_adv, addr_wrap;
  logic [CNT_W-1:0] cnt_q, cnt_d, step_cnt;
  logic             done_q, done_d;
  logic             addr_en, cnt_en;

  assign step_cnt = CNT_W'(step_bytes);

  always_comb begin
    addr_adv  = addr_q + AW'(step_bytes);
    addr_wrap = (addr_adv == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : addr_adv;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    if (step_en) begin
      addr_d = addr_wrap;
      if (cnt_q <= step_cnt) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - step_cnt;
      end
    end
    if (addr_load) addr_d = addr_value;
    if (cnt_load)  cnt_d  = cnt_value;
  end

  assign addr_en = step_en | addr_load;
  assign cnt_en  = step_en | cnt_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cur_addr  = addr_q;
  assign cur_count = cnt_q;
  assign done_set  = done_q;
endmodule

// File: rtl/rdma_station_prom.sv
module rdma_station_prom #(
  parameter int          PROM_BYTES   = 32,
  parameter logic [47:0] STATION_ADDR = 48'h0,
  parameter logic [7:0]  PROM_FILL    = 8'h57,
  parameter int          LANES        = 4,
  localparam int         PAW          = $clog2(PROM_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          wr_en,
  input  logic [LANES-1:0][PAW-1:0] idx,
  input  logic [LANES-1:0][7:0]     wdata,
  output logic [LANES-1:0][7:0]     rdata
);
  localparam int SRC_BYTES = PROM_BYTES / 2;

  function automatic logic [7:0] image_byte(input int b);
    int s;
    s = b / 2;
    if (s < 6)                   image_byte = STATION_ADDR[47 - 8*s -: 8];
    else if (s >= SRC_BYTES - 2) image_byte = PROM_FILL;
    else                         image_byte = 8'h00;
  endfunction

  logic [7:0] mem_q [PROM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < PROM_BYTES; b++) mem_q[b] <= image_byte(b);
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) mem_q[idx[l]] <= wdata[l];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rdata[l] = mem_q[idx[l]];
  end
endmodule

// File: rtl/rdma_packet_ram.sv
module rdma_packet_ram #(
  parameter int  RAM_BYTES = 2048,
  parameter int  LANES     = 4,
  localparam int RAW       = $clog2(RAM_BYTES)
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          wr_en,
  input  logic [LANES-1:0][RAW-1:0] idx,
  input  logic [LANES-1:0][7:0]     wdata,
  output logic [LANES-1:0][7:0]     rdata
);
  logic [7:0] mem_q [RAM_BYTES];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l]) mem_q[idx[l]] <= wdata[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rdata[l] = mem_q[idx[l]];
  end
endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port
  import rdma_pkg::*;
#(
  parameter int          PAGE_W       = 8,
  parameter int          CNT_W        = 16,
  parameter int          PROM_BYTES   = 32,
  parameter int          RAM_BASE     = 16384,
  parameter int          RAM_BYTES    = 2048,
  parameter logic [47:0] STATION_ADDR = 48'h02_00_00_00_00_01,
  parameter logic [7:0]  PROM_FILL    = 8'h57,
  localparam int         AW           = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic [PAGE_W-1:0] ring_start_pg,
  input  logic [PAGE_W-1:0] ring_stop_pg,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_value,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_long,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [AW-1:0]     cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              dma_done_set
);
  localparam int           PAW    = $clog2(PROM_BYTES);
  localparam int           RAW    = $clog2(RAM_BYTES);
  localparam logic [AW:0]  PROM_HI = (AW+1)'(PROM_BYTES);
  localparam logic [AW:0]  RAM_LO  = (AW+1)'(RAM_BASE);
  localparam logic [AW:0]  RAM_SZ  = (AW+1)'(RAM_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // beat width decode
  xfer_e      xf;
  logic [2:0] width;
  logic       cnt_nz, step_en, wr_go;
  logic [AW-1:0] eff_addr;

  always_comb begin
    if (acc_long)       xf = XF_LONG;
    else if (word_mode) xf = XF_WORD;
    else                xf = XF_BYTE;
  end

  assign width    = xfer_bytes(xf);
  assign cnt_nz   = (cur_count != '0);
  assign step_en  = acc_valid & (~acc_write | cnt_nz);
  assign wr_go    = acc_valid & acc_write & cnt_nz;
  assign eff_addr = (xf == XF_BYTE) ? cur_addr : {cur_addr[AW-1:1], 1'b0};

  // per-lane address decode
  logic [LANES-1:0][PAW-1:0] prom_idx;
  logic [LANES-1:0][RAW-1:0] ram_idx;
  logic [LANES-1:0][7:0]     lane_wdata, prom_rd, ram_rd, lane_rd;
  logic [LANES-1:0]          prom_we, ram_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] la, ram_off;
    logic          act, in_prom, in_ram;

    assign la      = eff_addr + AW'(l);
    assign ram_off = la - RAM_LO[AW-1:0];
    assign act     = (3'(l) < width);
    assign in_prom = ({1'b0, la} < PROM_HI);
    assign in_ram  = ({1'b0, la} >= RAM_LO) && ({1'b0, ram_off} < RAM_SZ);

    assign prom_idx[l]   = la[PAW-1:0];
    assign ram_idx[l]    = ram_off[RAW-1:0];
    assign lane_wdata[l] = acc_wdata[8*l +: 8];
    assign prom_we[l]    = wr_go & act & in_prom;
    assign ram_we[l]     = wr_go & act & in_ram;

    always_comb begin
      if (!act)         lane_rd[l] = 8'h00;
      else if (in_prom) lane_rd[l] = prom_rd[l];
      else if (in_ram)  lane_rd[l] = ram_rd[l];
      else              lane_rd[l] = 8'hFF;
    end
  end

  rdma_station_prom #(
    .PROM_BYTES  (PROM_BYTES),
    .STATION_ADDR(STATION_ADDR),
    .PROM_FILL   (PROM_FILL),
    .LANES       (LANES)
  ) u_prom (
    .clk  (clk),
    .rst_n(rst_int_n),
    .wr_en(prom_we),
    .idx  (prom_idx),
    .wdata(lane_wdata),
    .rdata(prom_rd)
  );

  rdma_packet_ram #(
    .RAM_BYTES(RAM_BYTES),
    .LANES    (LANES)
  ) u_ram (
    .clk  (clk),
    .wr_en(ram_we),
    .idx  (ram_idx),
    .wdata(lane_wdata),
    .rdata(ram_rd)
  );

  rdma_addr_seq #(
    .PAGE_W(PAGE_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_pg  (ring_start_pg),
    .stop_pg   (ring_stop_pg),
    .addr_load (addr_load),
    .addr_value(addr_value),
    .cnt_load  (cnt_load),
    .cnt_value (cnt_value),
    .step_en   (step_en),
    .step_bytes(width),
    .cur_addr  (cur_addr),
    .cur_count (cur_count),
    .done_set  (dma_done_set)
  );

  // registered read path
  logic [31:0] rd_q, rd_d;
  logic        rdv_q, rdv_d, rd_en;

  assign rd_en = acc_valid & ~acc_write;

  always_comb begin
    rd_d  = lane_rd;
    rdv_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      rdv_q <= rdv_d;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rdv_q;
endmodule

// File: rtl/rdma_data_port_chk.sv
module rdma_data_port_chk #(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int AW    = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_mode,
  input logic [PAGE_W-1:0] ring_start_pg,
  input logic [PAGE_W-1:0] ring_stop_pg,
  input logic              addr_load,
  input logic [AW-1:0]     addr_value,
  input logic              cnt_load,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_long,
  input logic              rd_valid,
  input logic [AW-1:0]     cur_addr,
  input logic [CNT_W-1:0]  cur_count,
  input logic              dma_done_set
);
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(acc_valid && !acc_write));

  p_done_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_set |-> (cur_count == '0));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !cnt_load && cur_count > CNT_W'(4)) |=>
    (cur_count == $past(cur_count) -
      ($past(acc_long) ? CNT_W'(4) : ($past(word_mode) ? CNT_W'(2) : CNT_W'(1)))));

  p_idle_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && cur_count == '0 && !addr_load && !cnt_load) |=>
    ($stable(cur_addr) && cur_count == '0 && !dma_done_set));

  p_never_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (!acc_write || cur_count != '0) && !addr_load &&
     ring_start_pg != ring_stop_pg) |=>
    (cur_addr != {$past(ring_stop_pg), 8'h00}));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (cur_addr == $past(addr_value)));
endmodule

bind rdma_data_port rdma_data_port_chk #(
  .PAGE_W(PAGE_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_mode    (word_mode),
  .ring_start_pg(ring_start_pg),
  .ring_stop_pg (ring_stop_pg),
  .addr_load    (addr_load),
  .addr_value   (addr_value),
  .cnt_load     (cnt_load),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_long     (acc_long),
  .rd_valid     (rd_valid),
  .cur_addr     (cur_addr),
  .cur_count    (cur_count),
  .dma_done_set (dma_done_set)
);

// File: tb/tb_rdma_data_port.sv
module tb_rdma_data_port;
  localparam logic [47:0] MAC = 48'h0A_1B_2C_3D_4E_5F;
  localparam int VW = 133;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic [7:0]  ring_start_pg = 8'h40;
  logic [7:0]  ring_stop_pg  = 8'h48;
  logic        addr_load = 1'b0;
  logic [15:0] addr_value = '0;
  logic        cnt_load = 1'b0;
  logic [15:0] cnt_value = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_long = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] cur_addr;
  logic [15:0] cur_count;
  logic        dma_done_set;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rdma_data_port #(
    .RAM_BASE(16384), .RAM_BYTES(2048), .STATION_ADDR(MAC), .PROM_FILL(8'h57)
  ) dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
    .addr_load(addr_load), .addr_value(addr_value),
    .cnt_load(cnt_load), .cnt_value(cnt_value),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_long(acc_long),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .cur_addr(cur_addr), .cur_count(cur_count), .dma_done_set(dma_done_set)
  );

  // entry: wr lng wm chk | addr cnt | wdata | exp_rd | exp_addr exp_cnt exp_done
  function automatic logic [VW-1:0] mk(
    input logic wr, lng, wm, chk, input logic [15:0] a, c,
    input logic [31:0] wd, erd, input logic [15:0] ea, ec, input logic ed);
    mk = {wr, lng, wm, chk, a, c, wd, erd, ea, ec, ed};
  endfunction

  localparam int NV = 22;
  localparam logic [VW-1:0] TBL [NV] = '{
    mk(1,0,0,0, 16'h4000, 16'd4, 32'h000000A5, 32'h0,        16'h4001, 16'd3, 0), // R1 byte write
    mk(1,0,1,0, 16'h4002, 16'd2, 32'h00001234, 32'h0,        16'h4004, 16'd0, 1), // R3 terminal
    mk(0,0,1,1, 16'h4002, 16'd2, 32'h0,        32'h00001234, 16'h4004, 16'd0, 1), // R7 word LE
    mk(0,0,0,1, 16'h4003, 16'd5, 32'h0,        32'h00000012, 16'h4004, 16'd4, 0), // R7 byte hi
    mk(1,1,0,0, 16'h4004, 16'd8, 32'hDEADBEEF, 32'h0,        16'h4008, 16'd4, 0), // R1 long
    mk(0,1,1,1, 16'h4004, 16'd3, 32'h0,        32'hDEADBEEF, 16'h4008, 16'd0, 1), // R3 cnt<width
    mk(0,0,1,1, 16'h4005, 16'd10,32'h0,        32'h0000BEEF, 16'h4007, 16'd8, 0), // R7 bit0 cleared
    mk(0,0,0,1, 16'h4000, 16'd1, 32'h0,        32'h000000A5, 16'h4001, 16'd0, 1), // R3 cnt==width
    mk(1,0,0,0, 16'h47FF, 16'd3, 32'h0000005A, 32'h0,        16'h4000, 16'd2, 0), // R2 wrap
    mk(0,0,0,1, 16'h47FF, 16'd1, 32'h0,        32'h0000005A, 16'h4000, 16'd0, 1), // R2 wrap read
    mk(1,0,1,0, 16'h47FE, 16'd6, 32'h0000C3C3, 32'h0,        16'h4000, 16'd4, 0), // R2 word wrap
    mk(0,0,1,1, 16'h47FE, 16'd6, 32'h0,        32'h0000C3C3, 16'h4000, 16'd4, 0), // R2
    mk(0,0,0,1, 16'h1000, 16'd2, 32'h0,        32'h000000FF, 16'h1001, 16'd1, 0), // R6 hole byte
    mk(0,0,1,1, 16'h2000, 16'd2, 32'h0,        32'h0000FFFF, 16'h2002, 16'd0, 1), // R6 hole word
    mk(0,1,0,1, 16'h5000, 16'd9, 32'h0,        32'hFFFFFFFF, 16'h5004, 16'd5, 0), // R6 hole long
    mk(0,0,1,1, 16'h0000, 16'd2, 32'h0,        32'h00000A0A, 16'h0002, 16'd0, 1), // R8 mac byte0
    mk(0,0,1,1, 16'h001C, 16'd2, 32'h0,        32'h00005757, 16'h001E, 16'd0, 1), // R8 fill
    mk(0,1,0,1, 16'h000A, 16'd8, 32'h0,        32'h00005F5F, 16'h000E, 16'd4, 0), // R8 mac5 + zero
    mk(0,1,0,1, 16'h001E, 16'd8, 32'h0,        32'hFFFF5757, 16'h0022, 16'd4, 0), // R6 per-lane
    mk(1,0,0,0, 16'h000C, 16'd2, 32'h00000077, 32'h0,        16'h000D, 16'd1, 0), // R8 prom write
    mk(0,0,0,1, 16'h000C, 16'd2, 32'h0,        32'h00000077, 16'h000D, 16'd1, 0), // R8 readback
    mk(0,0,0,1, 16'h4000, 16'd0, 32'h0,        32'h000000A5, 16'h4001, 16'd0, 1)  // R5 read at zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic load_regs(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    addr_load = 1'b1; addr_value = a;
    cnt_load  = 1'b1; cnt_value  = c;
    @(negedge clk);
    addr_load = 1'b0; cnt_load = 1'b0;
  endtask

  // drive one access at the current negedge, sample at the following negedge
  task automatic access(input logic wr, input logic lng, input logic wm, input logic [31:0] wd);
    acc_valid = 1'b1; acc_write = wr; acc_long = lng; word_mode = wm; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_long = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 addr", 32'(cur_addr), 32'h0);
    check("R11 count", 32'(cur_count), 32'h0);
    check("R11 rd_valid", 32'(rd_valid), 32'h0);
    check("R11 done", 32'(dma_done_set), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      load_regs(v[128:113], v[112:97]);
      access(v[132], v[131], v[130], v[96:65]);
      check($sformatf("R1/R2 addr vec%0d", i), 32'(cur_addr), 32'(v[32:17]));
      check($sformatf("R3 count vec%0d", i), 32'(cur_count), 32'(v[16:1]));
      check($sformatf("R3 done vec%0d", i), 32'(dma_done_set), 32'(v[0]));
      check($sformatf("R9 rd_valid vec%0d", i), 32'(rd_valid), 32'(!v[132]));
      if (v[129]) check($sformatf("R6/R7 rd_data vec%0d", i), rd_data, v[64:33]);
    end

    // R3 strobe lasts one cycle
    @(negedge clk);
    check("R3 done pulse width", 32'(dma_done_set), 32'h0);

    // R4 write at zero count is ignored, memory checked by a later read
    load_regs(16'h4000, 16'd0);
    access(1'b1, 1'b0, 1'b0, 32'h00000099);
    check("R4 addr held", 32'(cur_addr), 32'h4000);
    check("R4 count held", 32'(cur_count), 32'h0);
    check("R4 no done", 32'(dma_done_set), 32'h0);
    load_regs(16'h4000, 16'd1);
    access(1'b0, 1'b0, 1'b0, 32'h0);
    check("R4 memory untouched", rd_data, 32'h000000A5);

    // R10 load in the same cycle as an access
    load_regs(16'h4010, 16'd20);
    addr_load = 1'b1; addr_value = 16'h4100;
    access(1'b0, 1'b0, 1'b1, 32'h0);
    addr_load = 1'b0;
    check("R10 addr load wins", 32'(cur_addr), 32'h4100);
    check("R10 count still steps", 32'(cur_count), 32'd18);

    // R8 reset restores the PROM image
    do_reset();
    check("R11 count after reset", 32'(cur_count), 32'h0);
    load_regs(16'h000C, 16'd4);
    access(1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 overwritten byte restored", rd_data, 32'h00000000);
    load_regs(16'h0004, 16'd4);
    access(1'b0, 1'b0, 1'b1, 32'h0);
    check("R8 mac byte2 pair", rd_data, 32'h00002C2C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule